// File: doc/BRIEF.md
# Masked Interrupt Level Encoder

This block collects thirteen level-sensitive interrupt request lines from board peripherals and turns them into a single 4-bit interrupt level for a host processor. Each request line is placed at a fixed bit position of a 16-bit monitor word. A software-written 16-bit enable word gates that monitor word. Among the lines that are both asserted and enabled, the one with the best (smallest) priority rank wins. The winning rank is sent to the processor in inverted form, so a code of 0 means that nothing is requested.

Bit positions and priority ranks are two separate fixed orderings. Software enables a source by its bit position. The processor sees the source's rank. A small register bus with byte offsets inside a 64-byte window holds the following:
- the enable word;
- a power-off control word;
- a general output-port word;
- a constant version word.

The bus is plain control with strobes. It has no back-pressure: a read strobe always produces a read-valid pulse on the next cycle, and a write always completes in the cycle it is presented.

Top module: `irq_level_agg`

## Requirements
- R1: After reset, the enable, power-off and output-port words are 0, `irl_out` is 0, `pwr_off` and `out_port` are 0 and `bus_rvalid` is 0.
- R2: Request line `req_in[r]` (rank r) maps to an enable bit position as follows: rank 0→bit 11, 1→9, 2→8, 3→12, 4→10, 5→6, 6→5, 7→4, 8→7, 9→14, 10→13, 11→0, 12→15. A line takes part in arbitration only while it is high and its enable bit is 1.
- R3: Among the participating lines, the smallest rank wins, and `irl_out` equals that rank XOR 15. Rank 0 gives 15 and rank 12 gives 3.
- R4: When no line takes part, `irl_out` is 0.
- R5: `irl_out` is registered. After each rising edge, it reflects the request inputs sampled at that edge and the enable word held before that edge. A write to the enable word therefore changes `irl_out` one edge after the write edge. Requests are levels: lowering a line removes it at the next edge, and nothing is latched.
- R6: A read strobe sampled at an edge gives `bus_rvalid` = 1 for exactly the following cycle, with the data in `bus_rdata`. In every other cycle, `bus_rvalid` is 0 and `bus_rdata` is 0.
- R7: The enable word (offset 0x00), the power-off word (offset 0x30) and the output-port word (offset 0x36) each read back the full 16-bit value last written.
- R8: The version word at offset 0x32 always reads 0x0010. Writes to it have no effect.
- R9: Reads from any other offset return 0. Writes to any other offset change no register and do not change `irl_out`.
- R10: Enable bits 1, 2 and 3 belong to no source. They are stored and read back, but they never affect `irl_out`.
- R11: `pwr_off` and `out_port` always show the current power-off and output-port words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 13 | Level interrupt requests, index = priority rank |
| bus_addr | input | 6 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irl_out | output | 4 | Inverted interrupt level, 0 = no request |
| pwr_off | output | 16 | Current power-off word |
| out_port | output | 16 | Current output-port word |

## Verification
A wrong rank-to-bit mapping or a stuck enable bit shows at `irl_out` on the edge after the affected line rises with its enable bit set. To expose it, the bench enables each source alone and also pairs sources whose rank order differs from their bit order. Corrupted stored words show at `bus_rdata` one cycle after the read strobe. A stray write decode shows there as well, and it shows at `irl_out` one edge after the write if the write landed in the enable word. The bench also compares a long run of mixed enable and request patterns against a rank-table model, so any priority inversion appears within a cycle of the pattern that triggers it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_SRC  = 13;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 6;
  localparam int LEVEL_W  = 4;
  localparam logic [LEVEL_W-1:0] LEVEL_IDLE = '1;

  localparam logic [ADDR_W-1:0] OFS_ENABLE  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_PWROFF  = 6'h30;
  localparam logic [ADDR_W-1:0] OFS_VERSION = 6'h32;
  localparam logic [ADDR_W-1:0] OFS_OUTPORT = 6'h36;
  localparam logic [WORD_W-1:0] VERSION_VAL = 16'h0010;

  // Fixed placement of each priority rank inside the enable/monitor word.
  function automatic int rank_bit(input int rank);
    case (rank)
      0:  rank_bit = 11;
      1:  rank_bit = 9;
      2:  rank_bit = 8;
      3:  rank_bit = 12;
      4:  rank_bit = 10;
      5:  rank_bit = 6;
      6:  rank_bit = 5;
      7:  rank_bit = 4;
      8:  rank_bit = 7;
      9:  rank_bit = 14;
      10: rank_bit = 13;
      11: rank_bit = 0;
      default: rank_bit = 15;
    endcase
  endfunction
endpackage

// File: rtl/irq_monitor.sv
module irq_monitor
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = WORD_W
) (
  input  logic [N_SRC-1:0] req,
  output logic [W-1:0]     mon
);
  // Level-following placement of requests into the monitor word (R2).
  always_comb begin
    mon = '0;
    for (int r = 0; r < N_SRC; r++) begin
      mon[rank_bit(r)] = req[r];
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = WORD_W,
  parameter int LW    = LEVEL_W
) (
  input  logic [W-1:0]  mon,
  input  logic [W-1:0]  enable,
  output logic [LW-1:0] level_code
);
  localparam logic [LW-1:0] IDLE = '1;

  logic [W-1:0]  live;
  logic [N_SRC-1:0] part;
  logic [LW-1:0] rank_win;

  assign live = mon & enable;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_part
      assign part[g] = live[rank_bit(g)];
    end
  endgenerate

  // Scan from worst to best rank so the best participant is kept (R3, R4).
  always_comb begin
    rank_win = IDLE;
    for (int r = N_SRC - 1; r >= 0; r--) begin
      if (part[r]) rank_win = LW'(r);
    end
  end

  assign level_code = rank_win ^ IDLE;
endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
  import irq_agg_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic          rvalid,
  output logic [W-1:0]  enable_q,
  output logic [W-1:0]  pwroff_q,
  output logic [W-1:0]  outport_q
);
  logic [W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q  <= '0;
      pwroff_q  <= '0;
      outport_q <= '0;
    end else if (wr) begin
      case (addr)
        OFS_ENABLE:  enable_q  <= wdata;
        OFS_PWROFF:  pwroff_q  <= wdata;
        OFS_OUTPORT: outport_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFS_ENABLE:  rd_mux = enable_q;
      OFS_PWROFF:  rd_mux = pwroff_q;
      OFS_VERSION: rd_mux = VERSION_VAL;
      OFS_OUTPORT: rd_mux = outport_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? rd_mux : '0;
    end
  end

  // R6: read strobe gives exactly one valid cycle next
  a_r6_read_pulse: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (!rvalid && rdata == '0));
  // R8: version constant
  a_r8_version: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == OFS_VERSION) |=> rdata == VERSION_VAL);
  // R9: enable word only moves on its own write
  a_r9_enable_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == OFS_ENABLE) |=> $stable(enable_q));
endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int W     = WORD_W,
  parameter int AW    = ADDR_W,
  parameter int LW    = LEVEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_in,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [W-1:0]     bus_wdata,
  input  logic             bus_rd,
  output logic [W-1:0]     bus_rdata,
  output logic             bus_rvalid,
  output logic [LW-1:0]    irl_out,
  output logic [W-1:0]     pwr_off,
  output logic [W-1:0]     out_port
);
  logic [W-1:0]  mon_w;
  logic [W-1:0]  enable_q;
  logic [LW-1:0] level_next;

  irq_monitor #(.N_SRC(N_SRC), .W(W)) u_mon (
    .req (req_in),
    .mon (mon_w)
  );

  irq_bus_regs #(.W(W), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .rd        (bus_rd),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid),
    .enable_q  (enable_q),
    .pwroff_q  (pwr_off),
    .outport_q (out_port)
  );

  irq_prio_sel #(.N_SRC(N_SRC), .W(W), .LW(LW)) u_sel (
    .mon        (mon_w),
    .enable     (enable_q),
    .level_code (level_next)
  );

  always_ff @(posedge clk) begin
    if (rst) irl_out <= '0;
    else     irl_out <= level_next;
  end

  // R4: no request anywhere gives idle code next cycle
  a_r4_idle: assert property (@(posedge clk) disable iff (rst)
    !(|req_in) |=> irl_out == '0);
  // R3: best rank enabled wins outright
  a_r3_rank0_top: assert property (@(posedge clk) disable iff (rst)
    (req_in[0] && enable_q[rank_bit(0)]) |=> irl_out == LEVEL_IDLE);
  // R3: codes 1 and 2 are unreachable with ranks 0..12
  a_r3_code_range: assert property (@(posedge clk) disable iff (rst)
    irl_out == '0 || irl_out >= LW'(3));
endmodule

// File: tb/tb_irq_level_agg.sv
module tb_irq_level_agg;
  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] req_in;
  logic [5:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic        bus_rd;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [3:0]  irl_out;
  logic [15:0] pwr_off;
  logic [15:0] out_port;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4ns clk = ~clk;

  irq_level_agg dut (
    .clk(clk), .rst(rst), .req_in(req_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irl_out(irl_out),
    .pwr_off(pwr_off), .out_port(out_port)
  );

  // Model of R2/R3/R4
  function automatic logic [3:0] model_level(logic [12:0] rq, logic [15:0] en);
    int pos [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
    for (int r = 0; r < 13; r++)
      if (rq[r] && en[pos[r]]) return 4'(r) ^ 4'hF;
    return 4'h0;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Driver: push the expected read data into the scoreboard
  task automatic do_read(logic [5:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: pop and compare on each valid read
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected rvalid", 16'h1, 16'h0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8ns * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] m;
    rst = 1'b1; req_in = '0; bus_addr = '0; bus_wr = 0; bus_wdata = '0; bus_rd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irl_out", 16'(irl_out), 16'h0);
    check("R1 pwr_off", pwr_off, 16'h0);
    check("R1 out_port", out_port, 16'h0);
    check("R1 rvalid", 16'(bus_rvalid), 16'h0);
    do_read(6'h00, 16'h0000, "R1 enable reset");

    // R4: requests high but nothing enabled
    req_in = 13'h1FFF;
    @(negedge clk);
    check("R4 all masked", 16'(irl_out), 16'h0);

    // R5: enable write takes effect one edge after the write edge
    req_in = 13'h0001;
    do_write(6'h00, 16'h0800);
    check("R5 before extra edge", 16'(irl_out), 16'h0);
    @(negedge clk);
    check("R5 after enable write", 16'(irl_out), 16'hF);

    // R2/R3: each rank alone with only its own bit enabled
    for (int r = 0; r < 13; r++) begin
      int pos [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
      do_write(6'h00, 16'(1) << pos[r]);
      req_in = 13'(1) << r;
      @(negedge clk);
      check($sformatf("R2 rank %0d alone", r), 16'(irl_out), 16'(4'(r) ^ 4'hF));
      // wrong enable bit: nothing
      do_write(6'h00, ~(16'(1) << pos[r]));
      @(negedge clk);
      check($sformatf("R2 rank %0d own bit off", r), 16'(irl_out), 16'h0);
    end

    // R3: rank 3 (bit 12) beats rank 4 (bit 10); rank 11 (bit 0) beats rank 12
    do_write(6'h00, 16'hFFFF);
    req_in = (13'(1) << 3) | (13'(1) << 4);
    @(negedge clk);
    check("R3 rank3 over rank4", 16'(irl_out), 16'hC);
    req_in = (13'(1) << 11) | (13'(1) << 12);
    @(negedge clk);
    check("R3 rank11 over rank12", 16'(irl_out), 16'h4);
    req_in = 13'(1) << 12;
    @(negedge clk);
    check("R3 rank12 code", 16'(irl_out), 16'h3);
    // R5 level follow: drop request
    req_in = '0;
    @(negedge clk);
    check("R5 drop clears", 16'(irl_out), 16'h0);

    // R10: spare bits 1..3 stored but inert
    req_in = 13'h1FFF;
    do_write(6'h00, 16'h000E);
    @(negedge clk);
    check("R10 spare bits inert", 16'(irl_out), 16'h0);
    do_read(6'h00, 16'h000E, "R10 spare bits readback");

    // R7/R11: other registers
    do_write(6'h30, 16'hA5C3);
    do_write(6'h36, 16'h3C5A);
    check("R11 pwr_off", pwr_off, 16'hA5C3);
    check("R11 out_port", out_port, 16'h3C5A);
    do_read(6'h30, 16'hA5C3, "R7 pwroff readback");
    do_read(6'h36, 16'h3C5A, "R7 outport readback");

    // R8: version constant, writes ignored
    do_write(6'h32, 16'hFFFF);
    do_read(6'h32, 16'h0010, "R8 version after write");

    // R9: unlisted offsets
    do_write(6'h02, 16'hFFFF);
    do_write(6'h34, 16'hFFFF);
    do_write(6'h3F, 16'hFFFF);
    @(negedge clk);
    check("R9 irl unchanged", 16'(irl_out), 16'h0);
    do_read(6'h02, 16'h0000, "R9 unlisted read 0x02");
    do_read(6'h34, 16'h0000, "R9 unlisted read 0x34");
    do_read(6'h00, 16'h000E, "R9 enable untouched");
    do_read(6'h30, 16'hA5C3, "R9 pwroff untouched");
    do_read(6'h36, 16'h3C5A, "R9 outport untouched");

    // R3/R5: mixed patterns against the model
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m = lfsr;
      do_write(6'h00, m);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_in = lfsr[12:0] & {lfsr[3:0], lfsr[15:7]};
      @(negedge clk);
      check($sformatf("R3 mixed %0d", i), 16'(irl_out), 16'(model_level(req_in, m)));
    end

    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", 16'(exp_q.size()), 16'h0);
    done = 1;
    finish_run();
  end
endmodule